// File: doc/BRIEF.md
# Status Packet Generator

The block turns a parallel status word of 2 to 26 bits into a short byte-serial packet on a status return bus that many such generators share. When it has something to send it raises a request, holds its register address byte on the bus, and waits for a one-cycle start pulse from the downstream collector. The start pulse takes that address byte in the same cycle. On the following cycles the block drives the payload bytes back to back and leaves the bus at zero.

Software controls the block with a single control byte. The upper two bits pick a sending mode and the lower six bits hold a sequence number, which is stamped into every packet. In one-shot mode a write produces exactly one packet. In automatic mode a packet goes out whenever the status word changes. The status word is captured in the start cycle, so every byte of a packet comes from the same sample. The number of payload bytes follows the configured status width.

Top module: `status_packetizer`

## Requirements
- R1: Reset leaves the request low, the bus at 8'h00 and the mode off. While the mode is off, changes of the status word raise no request.
- R2: While the request is high, the bus carries the REG_ADDR byte. The request stays high until a start pulse arrives or the mode is written to off.
- R3: In the cycle after a start pulse the request is low. The payload then follows on consecutive cycles: {seq[5:0], status[1:0]}, then status[9:2], then status[17:10], then status[25:18].
- R4: All payload bytes come from the status word as it was in the start cycle. Later changes of the input do not alter the packet in progress.
- R5: A packet has 2 + ceil((PAYLOAD_W-2)/8) bytes including the address byte. Bits above PAYLOAD_W in the last byte are zero. In the cycle after the last byte the bus returns to 8'h00.
- R6: Writing control byte bits [7:6] = 2'b01 sends exactly one packet. Later status changes send nothing more.
- R7: With bits [7:6] = 2'b10 a packet is sent after each cycle in which the status word differs from its value in the cycle before. No packet is sent while the status word holds steady, and the write itself sends nothing.
- R8: Bits [7:6] = 2'b11 sends one packet at once and then behaves as in R7.
- R9: In automatic mode, any number of status changes during a packet in flight produce exactly one further packet. That packet carries the latest value.
- R10: Writing bits [7:6] = 2'b00 cancels a request that has not yet been started. The request drops in the next cycle and no packet follows.
- R11: A start pulse while the request is low has no effect. The bus stays at 8'h00 and the next packet is complete and correct.
- R12: The sequence field (bits [7:2] of the first payload byte) equals bits [5:0] of the most recent control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wd | input | 8 | Control byte: [7:6] mode, [5:0] sequence number |
| status_in | input | PAYLOAD_W | Parallel status word |
| pkt_byte | output | 8 | Packet byte bus (8'h00 when idle) |
| pkt_req | output | 1 | Request to send a packet |
| pkt_start | input | 1 | Start pulse from the collector, takes the address byte |

## Verification
The assertions check the handshake on every cycle. They confirm that the address byte is present whenever the request is high, that the request holds until start or cancel, and that it drops after start and stays low for the full packet length. They also check that the bus idles at zero, that the sequence and low status bits appear in the first payload byte, and that a send-now write raises the request. Only the bench scenarios can show the rest. That covers the snapshot property, the collapse of several in-flight changes into a single further packet, the silence of one-shot and off modes under changing status, and the packet being shortened for a narrow status word.

// File: rtl/spg_pkg.sv
package spg_pkg;

    localparam int SEQ_W     = 6;
    localparam int BYTE_W    = 8;
    localparam int HEAD_BITS = 2;   // status bits that share the byte with the sequence number

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_ONCE     = 2'b01,
        MODE_AUTO     = 2'b10,
        MODE_AUTO_NOW = 2'b11
    } spg_mode_e;

    typedef struct packed {
        spg_mode_e          mode;
        logic [SEQ_W-1:0]   seq;
    } spg_ctl_t;

    // total bytes on the bus for one packet, address byte included
    function automatic int pkt_len(input int payload_w);
        return (payload_w > HEAD_BITS) ? 2 + (payload_w - HEAD_BITS + BYTE_W - 1) / BYTE_W : 2;
    endfunction

    function automatic logic auto_on(input spg_mode_e m);
        return m[1];
    endfunction

    function automatic logic send_now(input spg_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/spg_trigger.sv
module spg_trigger
    import spg_pkg::*;
#(
    parameter int PAYLOAD_W = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_we,
    input  logic [BYTE_W-1:0]    ctl_wd,
    input  logic [PAYLOAD_W-1:0] status_in,
    input  logic                 accept,
    output logic                 pending,
    output logic [SEQ_W-1:0]     seq
);

    spg_ctl_t               ctl_q;
    spg_ctl_t               ctl_in;
    logic [PAYLOAD_W-1:0]   prev_q;
    logic                   pend_q;
    logic                   pend_d;
    logic                   changed;

    assign ctl_in  = spg_ctl_t'(ctl_wd);
    assign changed = (status_in != prev_q);

    // later assignments take priority: control write over change over accept
    always_comb begin
        pend_d = pend_q;
        if (accept)
            pend_d = 1'b0;
        if (auto_on(ctl_q.mode) && changed)
            pend_d = 1'b1;
        if (ctl_we) begin
            if (ctl_in.mode == MODE_OFF)
                pend_d = 1'b0;
            else if (send_now(ctl_in.mode))
                pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{mode: MODE_OFF, seq: '0};
            prev_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (ctl_we)
                ctl_q <= ctl_in;
            prev_q <= status_in;
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;
    assign seq     = ctl_q.seq;

endmodule

// File: rtl/spg_serializer.sv
module spg_serializer
    import spg_pkg::*;
#(
    parameter int              PAYLOAD_W = 26,
    parameter logic [7:0]      REG_ADDR  = 8'h3C
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pending,
    input  logic [SEQ_W-1:0]     seq,
    input  logic [PAYLOAD_W-1:0] status_in,
    input  logic                 start,
    output logic                 accept,
    output logic                 req,
    output logic [BYTE_W-1:0]    bus
);

    localparam int NBYTES = pkt_len(PAYLOAD_W);
    localparam int IDX_W  = $clog2(NBYTES);
    localparam int PADW   = HEAD_BITS + BYTE_W * (NBYTES - 2);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

    logic                   busy_q;
    logic [IDX_W-1:0]       idx_q;
    logic [PAYLOAD_W-1:0]   snap_q;
    logic [SEQ_W-1:0]       seq_q;
    logic [PADW-1:0]        padded;
    logic [BYTE_W-1:0]      lane [NBYTES];

    assign padded = PADW'(snap_q);

    generate
        for (genvar k = 0; k < NBYTES; k++) begin : g_lane
            if (k == 0) begin : g_addr
                assign lane[k] = REG_ADDR;
            end else if (k == 1) begin : g_head
                assign lane[k] = {seq_q, padded[HEAD_BITS-1:0]};
            end else begin : g_body
                assign lane[k] = padded[BYTE_W*k - 14 +: BYTE_W];
            end
        end
    endgenerate

    assign req    = pending && !busy_q;
    assign accept = req && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            snap_q <= '0;
            seq_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= IDX_W'(1);
            snap_q <= status_in;
            seq_q  <= seq;
        end else if (busy_q) begin
            if (idx_q == LAST) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q  <= idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        if (req)
            bus = lane[0];
        else if (busy_q)
            bus = lane[idx_q];
        else
            bus = '0;
    end

endmodule

// File: rtl/status_packetizer.sv
module status_packetizer
    import spg_pkg::*;
#(
    parameter int         PAYLOAD_W = 26,
    parameter logic [7:0] REG_ADDR  = 8'h3C
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_we,
    input  logic [7:0]           ctl_wd,
    input  logic [PAYLOAD_W-1:0] status_in,
    output logic [7:0]           pkt_byte,
    output logic                 pkt_req,
    input  logic                 pkt_start
);

    logic               pending;
    logic               accept;
    logic [SEQ_W-1:0]   seq;

    spg_trigger #(
        .PAYLOAD_W (PAYLOAD_W)
    ) u_trigger (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wd    (ctl_wd),
        .status_in (status_in),
        .accept    (accept),
        .pending   (pending),
        .seq       (seq)
    );

    spg_serializer #(
        .PAYLOAD_W (PAYLOAD_W),
        .REG_ADDR  (REG_ADDR)
    ) u_serializer (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending),
        .seq       (seq),
        .status_in (status_in),
        .start     (pkt_start),
        .accept    (accept),
        .req       (pkt_req),
        .bus       (pkt_byte)
    );

endmodule

// File: rtl/status_packetizer_chk.sv
module status_packetizer_chk
    import spg_pkg::*;
#(
    parameter int         PAYLOAD_W = 26,
    parameter logic [7:0] REG_ADDR  = 8'h3C
) (
    input logic       clk,
    input logic       rst,
    input logic       ctl_we,
    input logic [7:0] ctl_wd,
    input logic [1:0] stat_lo,
    input logic [7:0] pkt_byte,
    input logic       pkt_req,
    input logic       pkt_start
);

    localparam int NBYTES = pkt_len(PAYLOAD_W);
    localparam logic [2:0] FIRST_PAY = 3'(NBYTES - 1);

    logic [2:0] flight_cnt;
    logic [5:0] seq_seen;
    logic [7:0] head_exp;
    logic       taken;
    logic       off_wr;

    assign taken  = pkt_req && pkt_start;
    assign off_wr = ctl_we && (ctl_wd[7:6] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            flight_cnt <= '0;
            seq_seen   <= '0;
            head_exp   <= '0;
        end else begin
            if (ctl_we)
                seq_seen <= ctl_wd[5:0];
            if (taken) begin
                flight_cnt <= FIRST_PAY;
                head_exp   <= {seq_seen, stat_lo};
            end else if (flight_cnt != 3'd0) begin
                flight_cnt <= flight_cnt - 3'd1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!pkt_req && pkt_byte == 8'h00)); // R1
    AST_ADDR_ON_REQ: assert property (@(posedge clk) disable iff (rst) pkt_req |-> pkt_byte == REG_ADDR); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst) (pkt_req && !pkt_start && !off_wr) |=> pkt_req); // R2
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst) taken |=> !pkt_req); // R3
    AST_FLIGHT_NO_REQ: assert property (@(posedge clk) disable iff (rst) (flight_cnt != 3'd0) |-> !pkt_req); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) (flight_cnt == 3'd0 && !pkt_req) |-> pkt_byte == 8'h00); // R11
    AST_ONCE_RAISE: assert property (@(posedge clk) disable iff (rst) (ctl_we && ctl_wd[6] && flight_cnt <= 3'd1 && !taken) |=> pkt_req); // R6
    AST_OFF_CANCEL: assert property (@(posedge clk) disable iff (rst) (off_wr && !taken) |=> !pkt_req); // R10
    AST_SEQ_FIELD: assert property (@(posedge clk) disable iff (rst) (flight_cnt == FIRST_PAY && flight_cnt != 3'd0) |-> pkt_byte == head_exp); // R12

endmodule

bind status_packetizer status_packetizer_chk #(
    .PAYLOAD_W (PAYLOAD_W),
    .REG_ADDR  (REG_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_wd    (ctl_wd),
    .stat_lo   (status_in[1:0]),
    .pkt_byte  (pkt_byte),
    .pkt_req   (pkt_req),
    .pkt_start (pkt_start)
);

// File: tb/status_packetizer_test.sv
module status_packetizer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WIDE_W  = 26;
    localparam int SHORT_W = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [7:0]  wd  = 8'h00;
    logic [25:0] st  = '0;
    logic        start_a = 1'b0;
    logic        start_b = 1'b0;
    logic [7:0]  byte_a, byte_b;
    logic        req_a, req_b;

    int vectors = 0;
    int errors  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_packetizer #(.PAYLOAD_W(WIDE_W), .REG_ADDR(8'h3C)) uut (
        .clk(clk), .rst(rst), .ctl_we(we), .ctl_wd(wd), .status_in(st),
        .pkt_byte(byte_a), .pkt_req(req_a), .pkt_start(start_a));

    status_packetizer #(.PAYLOAD_W(SHORT_W), .REG_ADDR(8'h3E)) uut_short (
        .clk(clk), .rst(rst), .ctl_we(we), .ctl_wd(wd), .status_in(st[9:0]),
        .pkt_byte(byte_b), .pkt_req(req_b), .pkt_start(start_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic cur_req(input bit b);
        return b ? req_b : req_a;
    endfunction

    function automatic logic [7:0] cur_byte(input bit b);
        return b ? byte_b : byte_a;
    endfunction

    function automatic logic [7:0] exp_byte(input int k, input logic [25:0] s,
                                            input logic [5:0] q, input int w);
        logic [25:0] m;
        m = (w >= 26) ? s : (s & ((26'd1 << w) - 26'd1));
        if (k == 1) return {q, m[1:0]};
        return 8'(m >> (8*k - 14));
    endfunction

    task automatic write_ctl(input logic [1:0] mode, input logic [5:0] seq);
        we = 1'b1;
        wd = {mode, seq};
        tick();
        we = 1'b0;
        wd = 8'h00;
    endtask

    task automatic expect_quiet(input bit b, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk({tag, " request low"}, 32'(cur_req(b)), 32'd0);
            chk({tag, " bus idle"}, 32'(cur_byte(b)), 32'd0);
            tick();
        end
    endtask

    // waits for the request, starts the packet and checks every byte of it
    task automatic grab(input bit b, input logic [25:0] exp_st, input logic [5:0] exp_seq,
                        input string tag, input bit mutate);
        int w;
        int nb;
        int waitc;
        w  = b ? SHORT_W : WIDE_W;
        nb = 2 + (w - 2 + 7) / 8;
        waitc = 0;
        while (!cur_req(b) && waitc < 20) begin
            tick();
            waitc++;
        end
        chk({tag, " R2 request raised"}, 32'(cur_req(b)), 32'd1);
        chk({tag, " R2 address byte"}, 32'(cur_byte(b)), b ? 32'h3E : 32'h3C);
        if (b) start_b = 1'b1; else start_a = 1'b1;
        tick();
        start_a = 1'b0;
        start_b = 1'b0;
        for (int k = 1; k < nb; k++) begin
            if (mutate && k == 1) st = ~st;
            if (mutate && k == 2) st = st ^ 26'h155;
            chk({tag, " R3 request low in flight"}, 32'(cur_req(b)), 32'd0);
            chk($sformatf("%s R3/R12 byte %0d", tag, k), 32'(cur_byte(b)),
                32'(exp_byte(k, exp_st, exp_seq, w)));
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [25:0] v;
        logic [25:0] last;

        // R1: reset state, mode off ignores status changes
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset request", 32'(req_a), 32'd0);
        chk("R1 reset bus", 32'(byte_a), 32'd0);
        chk("R1 reset request short", 32'(req_b), 32'd0);
        for (int i = 0; i < 4; i++) begin
            st = 26'(i * 32'h0015_3A7F + 1);
            tick();
            chk("R1 mode off ignores change", 32'(req_a), 32'd0);
        end

        // R3 R12 R6: exhaustive sequence number x low status bits
        for (int q = 0; q < 64; q++) begin
            for (int lo = 0; lo < 4; lo++) begin
                v = 26'((q * 4 + lo) * 32'h00A5_3C97);
                v[1:0] = 2'(lo);
                st = v;
                write_ctl(2'b01, 6'(q));
                grab(1'b0, v, 6'(q), "R12 sweep", 1'b0);
                expect_quiet(1'b0, 1, "R6 once");
            end
        end

        // R3: walking one across the whole status word
        for (int b = 0; b < WIDE_W; b++) begin
            v = 26'd1 << b;
            st = v;
            write_ctl(2'b01, 6'(b));
            grab(1'b0, v, 6'(b), "R3 walk", 1'b0);
            expect_quiet(1'b0, 1, "R5 end of packet");
        end

        // R4 R6: snapshot at start, one-shot ignores changes afterwards
        v = 26'h2C3_5A96;
        st = v;
        write_ctl(2'b01, 6'd17);
        grab(1'b0, v, 6'd17, "R4 snapshot", 1'b1);
        expect_quiet(1'b0, 4, "R6 once no repeat");

        // R11: start while idle is ignored
        write_ctl(2'b00, 6'd0);
        start_a = 1'b1;
        expect_quiet(1'b0, 3, "R11 start ignored");
        start_a = 1'b0;
        v = 26'h1F0_0C3A;
        st = v;
        write_ctl(2'b01, 6'd33);
        grab(1'b0, v, 6'd33, "R11 after stray start", 1'b0);

        // R10: cancel a waiting request
        write_ctl(2'b01, 6'd2);
        chk("R10 request before cancel", 32'(req_a), 32'd1);
        write_ctl(2'b00, 6'd2);
        expect_quiet(1'b0, 4, "R10 cancelled");

        // R7: automatic mode sends on each change only
        write_ctl(2'b10, 6'd5);
        expect_quiet(1'b0, 4, "R7 no change no packet");
        for (int i = 0; i < 8; i++) begin
            v = 26'((i + 3) * 32'h0137_9BDF);
            st = v;
            tick();
            grab(1'b0, v, 6'd5, "R7 auto", 1'b0);
            expect_quiet(1'b0, 3, "R7 steady");
        end

        // R9: changes in flight give exactly one more packet with the latest value
        for (int i = 0; i < 4; i++) begin
            v = 26'((i + 11) * 32'h00F3_1D25);
            st = v;
            tick();
            grab(1'b0, v, 6'd5, "R9 first", 1'b1);
            last = st;
            grab(1'b0, last, 6'd5, "R9 follow-up", 1'b0);
            expect_quiet(1'b0, 5, "R9 only one more");
        end

        // R8: send now plus automatic
        write_ctl(2'b00, 6'd0);
        v = 26'h0AB_CDEF;
        st = v;
        tick();
        write_ctl(2'b11, 6'd9);
        chk("R8 immediate request", 32'(req_a), 32'd1);
        grab(1'b0, v, 6'd9, "R8 now", 1'b0);
        expect_quiet(1'b0, 3, "R8 steady");
        v = 26'h355_0011;
        st = v;
        tick();
        grab(1'b0, v, 6'd9, "R8 auto", 1'b0);
        expect_quiet(1'b0, 2, "R8 steady after auto");

        // R5: narrow instance sends a three-byte packet
        write_ctl(2'b00, 6'd0);
        for (int i = 0; i < 14; i++) begin
            v = (i < 10) ? (26'h3FF_FC00 | (26'd1 << i)) : 26'((i + 1) * 32'h02D9_E5B3);
            st = v;
            write_ctl(2'b01, 6'(40 + i));
            grab(1'b1, v, 6'(40 + i), "R5 short", 1'b0);
            expect_quiet(1'b1, 1, "R5 short length");
        end
        write_ctl(2'b00, 6'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule